// File: doc/BRIEF.md
# Synchronized Rising-Edge Pulse Generator

This block turns a slow, asynchronous level, such as a push-button held by a person, into exactly one clock-wide pulse for each low-to-high change of that level. The raw level first passes through a chain of two synchronizing flip-flops. Only the second stage is visible to the rest of the logic. An edge-detecting state machine then produces the pulse. A pulse-driven toggle register flips its output once per press, which suits an on/off control.

A parameter selects the edge detector. The registered-output style uses three states: `ST_LOW` (level low, waiting for a rise, code 00), `ST_EDGE` (rise seen, code 01) and `ST_HIGH` (level high, waiting for a fall, code 11). Its transitions are:
- `ST_LOW -> ST_EDGE` when the synchronized level is 1.
- `ST_EDGE -> ST_HIGH` when the level stays 1.
- `ST_EDGE -> ST_LOW` when the level is 0.
- `ST_HIGH -> ST_LOW` when the level is 0.
- The unused code 10 goes to `ST_LOW`.

The combinational-output style keeps one state bit, `MS_LOW` or `MS_HIGH`, which holds the previous synchronized level. Its pulse is the present level AND NOT that bit, so its pulse comes one cycle earlier.

Top module: `rise_pulse_gen`

## Requirements
- R1: The raw input reaches the edge logic only through two synchronizing registers, so the synchronized level equals the raw level sampled two clock edges earlier.
- R2: In the registered style, the state codes are `ST_LOW`=00, `ST_EDGE`=01 and `ST_HIGH`=11, and the transitions are the ones listed above.
- R3: In the registered style, `pulse_out` is high exactly while the state is `ST_EDGE`. It rises one clock after the edge at which the raw rise is sampled plus two synchronizer edges, that is, in the clock period after the third edge.
- R4: In the combinational style, `pulse_out` = synchronized level AND NOT stored bit. It is high in the clock period after the second edge following the sampled rise, one cycle before the registered style.
- R5: Every sampled rise of `level_in` gives exactly one pulse of one clock period, whether the input is held for one cycle or for many. A change that begins and ends between two clock edges gives no pulse.
- R6: `toggle_out` inverts at each clock edge where `pulse_out` is high and holds otherwise.
- R7: While `rst` is high at a clock edge, both synchronizer stages, the state and the toggle register clear to 0. `pulse_out` and `toggle_out` read 0 after that edge.
- R8: The registered-style state never holds code 10. If it ever did, the next state would be `ST_LOW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all registers |
| rst | input | 1 | Synchronous reset, active high |
| level_in | input | 1 | Raw asynchronous level |
| pulse_out | output | 1 | One-cycle pulse per rise |
| toggle_out | output | 1 | Flips once per pulse |

## Verification
Two events can meet in one cycle. The first is a new rise arriving right after a one-cycle low gap while the detector is still leaving `ST_EDGE` or `MS_HIGH`. The second is reset arriving while a pulse is pending or a toggle is about to flip. The bench provokes both by pressing with one-cycle gaps and by raising reset in the middle of a press. A behavioural model built on a queue of sampled input values judges every cycle. It also checks that the number of pulses equals the number of sampled rises for both styles.

// File: rtl/rise_pulse_pkg.sv
package rise_pulse_pkg;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        ST_LOW  = 2'b00,
        ST_EDGE = 2'b01,
        ST_HIGH = 2'b11
    } reg_state_t;

    typedef enum logic {
        MS_LOW  = 1'b0,
        MS_HIGH = 1'b1
    } cmb_state_t;
endpackage

// File: rtl/level_sync.sv
module level_sync #(
    parameter int STAGES = rise_pulse_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[TOP-1:0], din};
        end
    end

    assign dout = chain[TOP];
endmodule

// File: rtl/edge_fsm_reg.sv
module edge_fsm_reg
    import rise_pulse_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    output logic       pulse,
    output logic [1:0] code
);
    reg_state_t state;
    reg_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LOW;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = ST_LOW;
        unique case (state)
            ST_LOW:  nxt = lvl ? ST_EDGE : ST_LOW;
            ST_EDGE: nxt = lvl ? ST_HIGH : ST_LOW;
            ST_HIGH: nxt = lvl ? ST_HIGH : ST_LOW;
            default: nxt = ST_LOW;
        endcase
    end

    always_comb begin
        pulse = 1'b0;
        unique case (state)
            ST_EDGE: pulse = 1'b1;
            default: pulse = 1'b0;
        endcase
    end

    assign code = state;
endmodule

// File: rtl/edge_fsm_cmb.sv
module edge_fsm_cmb
    import rise_pulse_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    output logic       pulse,
    output logic [1:0] code
);
    cmb_state_t state;
    cmb_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MS_LOW;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = lvl ? MS_HIGH : MS_LOW;
    end

    always_comb begin
        pulse = 1'b0;
        unique case (state)
            MS_LOW:  pulse = lvl;
            MS_HIGH: pulse = 1'b0;
            default: pulse = 1'b0;
        endcase
    end

    assign code = {state, state};
endmodule

// File: rtl/press_toggle.sv
module press_toggle (
    input  logic clk,
    input  logic rst,
    input  logic pulse,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (pulse) begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/rise_pulse_gen.sv
module rise_pulse_gen #(
    parameter bit USE_COMB = 1'b0,
    parameter int SYNC_N   = rise_pulse_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic pulse_out,
    output logic toggle_out
);
    logic       sync_lvl;
    logic       det_pulse;
    logic [1:0] fsm_code;

    level_sync #(.STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (level_in),
        .dout (sync_lvl)
    );

    generate
        if (USE_COMB) begin : g_cmb
            edge_fsm_cmb u_det (
                .clk   (clk),
                .rst   (rst),
                .lvl   (sync_lvl),
                .pulse (det_pulse),
                .code  (fsm_code)
            );
        end else begin : g_reg
            edge_fsm_reg u_det (
                .clk   (clk),
                .rst   (rst),
                .lvl   (sync_lvl),
                .pulse (det_pulse),
                .code  (fsm_code)
            );
        end
    endgenerate

    press_toggle u_tog (
        .clk   (clk),
        .rst   (rst),
        .pulse (det_pulse),
        .q     (toggle_out)
    );

    assign pulse_out = det_pulse;
endmodule

// File: rtl/rise_pulse_chk.sv
module rise_pulse_chk #(
    parameter bit USE_COMB = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       level_in,
    input logic       pulse_out,
    input logic       toggle_out,
    input logic       sync_lvl,
    input logic [1:0] fsm_code
);
    logic [1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 2'd0;
        end else if (run != 2'd3) begin
            run <= run + 2'd1;
        end
    end

    assert_sync_delay_R1: assert property (@(posedge clk) disable iff (rst)
        (run >= 2'd2) |-> (sync_lvl == $past(level_in, 2)));

    assert_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        pulse_out |=> !pulse_out);

    generate
        if (USE_COMB) begin : g_cmb_chk
            assert_comb_latency_R4: assert property (@(posedge clk) disable iff (rst)
                (run >= 2'd1) |-> (pulse_out == (sync_lvl && !$past(sync_lvl))));
        end else begin : g_reg_chk
            assert_reg_latency_R3: assert property (@(posedge clk) disable iff (rst)
                (run >= 2'd2) |-> (pulse_out == ($past(sync_lvl) && !$past(sync_lvl, 2))));
            assert_code_legal_R8: assert property (@(posedge clk) disable iff (rst)
                (run >= 2'd1) |-> (fsm_code != 2'b10));
            assert_edge_exit_R2: assert property (@(posedge clk) disable iff (rst)
                (fsm_code == 2'b01) |=> (fsm_code != 2'b01));
        end
    endgenerate

    assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (rst)
        (run >= 2'd1) |-> ((toggle_out != $past(toggle_out)) == $past(pulse_out)));

    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> (!pulse_out && !toggle_out));
endmodule

bind rise_pulse_gen rise_pulse_chk #(.USE_COMB(USE_COMB)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .level_in   (level_in),
    .pulse_out  (pulse_out),
    .toggle_out (toggle_out),
    .sync_lvl   (sync_lvl),
    .fsm_code   (fsm_code)
);

// File: tb/tb_rise_pulse_gen.sv
module tb_rise_pulse_gen;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raw = 1'b0;
    logic p_reg, t_reg, p_cmb, t_cmb;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    bit hist[$];
    bit exp_p_reg = 1'b0, exp_p_cmb = 1'b0;
    bit exp_t_reg = 1'b0, exp_t_cmb = 1'b0;
    int rises = 0, cnt_reg = 0, cnt_cmb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rise_pulse_gen #(.USE_COMB(1'b0)) dut (
        .clk(clk), .rst(rst), .level_in(raw), .pulse_out(p_reg), .toggle_out(t_reg));

    rise_pulse_gen #(.USE_COMB(1'b1)) dut_cmb (
        .clk(clk), .rst(rst), .level_in(raw), .pulse_out(p_cmb), .toggle_out(t_cmb));

    task automatic check(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string req);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Reference: queue of sampled raw values; index 0 is the newest sample.
    always @(posedge clk) begin
        if (rst) begin
            hist = '{1'b0, 1'b0, 1'b0, 1'b0};
            exp_p_reg = 1'b0; exp_p_cmb = 1'b0;
            exp_t_reg = 1'b0; exp_t_cmb = 1'b0;
            rises = 0;
        end else begin
            exp_t_reg ^= exp_p_reg;
            exp_t_cmb ^= exp_p_cmb;
            hist.push_front(raw);
            void'(hist.pop_back());
            // R1: level seen by the detector is the sample from two edges back
            exp_p_cmb = hist[1] && !hist[2];
            exp_p_reg = hist[2] && !hist[3];
            if (hist[0] && !hist[1]) rises++;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                cnt_reg = 0;
                cnt_cmb = 0;
                check(p_reg, 1'b0, "R7 reg pulse in reset");
                check(t_reg, 1'b0, "R7 reg toggle in reset");
                check(p_cmb, 1'b0, "R7 cmb pulse in reset");
                check(t_cmb, 1'b0, "R7 cmb toggle in reset");
            end else begin
                if (p_reg === 1'b1) cnt_reg++;
                if (p_cmb === 1'b1) cnt_cmb++;
                check(p_reg, exp_p_reg, "R2 R3 reg pulse");
                check(p_cmb, exp_p_cmb, "R4 cmb pulse");
                check(t_reg, exp_t_reg, "R6 reg toggle");
                check(t_cmb, exp_t_cmb, "R6 cmb toggle");
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic press(input int width, input int gap);
        @(negedge clk); #1 raw = 1'b1;
        repeat (width) @(negedge clk);
        #1 raw = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic count_check(input string tag);
        idle(6);
        check_int(cnt_reg, rises, {"R5 reg pulse count ", tag});
        check_int(cnt_cmb, rises, {"R5 cmb pulse count ", tag});
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(4);
        // R5 varying widths and gaps
        press(1, 6);
        press(2, 1);
        press(1, 1);
        press(3, 2);
        press(10, 5);
        press(50, 3);
        count_check("widths");
        // R5 glitch between edges: no sample, no pulse
        @(negedge clk); #1 raw = 1'b1; #2 raw = 1'b0;
        idle(6);
        check_int(cnt_reg, rises, "R5 glitch reg");
        check_int(cnt_cmb, rises, "R5 glitch cmb");
        // R7 reset while a press is in flight
        press(1, 0);
        #1 rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(4);
        // R7 reset with level held high: first sample after reset is a rise
        raw = 1'b1;
        idle(2);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(8);
        raw = 1'b0;
        idle(4);
        check_int(cnt_reg, rises, "R7 held-through-reset reg");
        for (int i = 0; i < 20; i++) begin
            press(1 + (i % 4), 1 + (i % 3));
        end
        count_check("burst");
        done = 1'b1;
        summary();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule